// File: doc/BRIEF.md
# Scanned Key Matrix Emulator with Paced Event Queue

This block stands in for a physical key matrix in front of a host's keyboard scanning logic. The host drives a vector of strobe (column) lines and reads back a vector of sense (row) lines. Internally, the block keeps one pressed-key mask per row. Each sense line is high whenever its row has a pressed key in any column whose strobe is active.

Key events arrive as 8-bit scan codes. Bit 7 marks a release, and the low seven bits select a position through a computed map. Events enter a small queue. A free-running tick counter releases one event per tick period, which paces the matrix changes so that a slow scanner sees each of them.

Some codes map to a pseudo-row that sits just past the last real row. These codes do not touch the matrix. Instead they drive a set of discrete button outputs.

Top module: `kbd_matrix_emu`

## Requirements
- R1: While reset is asserted, every sense output, every button output and the overflow flag are 0, every pressed-key mask is cleared, and any queued events are discarded, so none of them take effect after reset is released.
- R2: Sense output i equals the OR over columns c of (row i pressed bit c AND strobe[c]). It follows a strobe change combinationally, in the same cycle, and it is 0 whenever all strobes are 0.
- R3: A 7-bit code value v below NUM_SENSE*NUM_STROBE (77 by default) maps to row v/NUM_STROBE and column v%NUM_STROBE. For example, code 12 is row 1, column 1, and code 76 is row 6, column 10.
- R4: A code with bit 7 clear is a press and sets the mapped matrix bit. A code with bit 7 set is a release and clears that bit. Releasing a key that is not pressed leaves the matrix unchanged.
- R5: Code values BTN_BASE to BTN_BASE+NUM_BTN-1 (80 to 84 by default) map to the pseudo-row. A press drives button[v-BTN_BASE] high, a release drives it low, and the sense outputs are not affected.
- R6: Codes that map to neither the matrix nor a button are dropped: they cause no change on the sense or button outputs. By default these are the values 77 to 79 and 85 to 127, with either value of bit 7.
- R7: Queued events take effect in arrival order, one event per tick. Ticks occur every TICK_CYCLES clock cycles, so two events queued together take effect exactly TICK_CYCLES cycles apart.
- R8: The queue holds QUEUE_DEPTH events (16 by default). A push arriving while the queue is full, and not freed by a pop in the same cycle, is dropped and sets the overflow output. Overflow then stays high until reset.
- R9: The queue storage wraps around. Event order is preserved after more than QUEUE_DEPTH events have passed through it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Push the scan code on ev_code this cycle |
| ev_code | input | 8 | Scan code; bit 7 = release, bits 6:0 = key value |
| strobe | input | NUM_STROBE | Column strobes driven by the host scanner, active high |
| sense | output | NUM_SENSE | Row sense lines, active high |
| button | output | NUM_BTN | Discrete side-band button levels |
| overflow | output | 1 | Sticky flag: an event was lost because the queue was full |

## Verification
The matrix is loaded with keys at the first, middle and last positions. It is then read back under an all-ones strobe, under single-column strobes and under an all-zero strobe, which separates row decoding from column decoding and from a stuck sense line. Press/release sequences on one key check both that the right bit is set or cleared and that the queue keeps arrival order across a pointer wrap. Pseudo-row and unmapped codes are applied on top of a known matrix state, so any leakage into the sense lines or buttons shows up. The spacing between two back-to-back events is measured in cycles, and a burst larger than the queue is used to test drop and overflow behaviour.

// File: rtl/kmx_pkg.sv
package kmx_pkg;

   typedef struct packed {
      logic [3:0] row;
      logic [3:0] col;
   } kmx_pos_t;

   localparam kmx_pos_t KMX_UNMAPPED = '{row: 4'hF, col: 4'hF};

   // Key value -> matrix position. Values below rows*cols fill the matrix
   // row by row; a run of nbtn values from btn_base lands on the pseudo-row
   // numbered 'rows'; everything else is unmapped.
   function automatic kmx_pos_t kmx_lookup(input logic [6:0] value,
                                           input int rows, input int cols,
                                           input int btn_base, input int nbtn);
      int v;
      kmx_pos_t p;
      v = int'(value);
      if (v < rows * cols) begin
         p.row = 4'(v / cols);
         p.col = 4'(v % cols);
      end else if (v >= btn_base && v < btn_base + nbtn) begin
         p.row = 4'(rows);
         p.col = 4'(v - btn_base);
      end else begin
         p = KMX_UNMAPPED;
      end
      return p;
   endfunction

endpackage

// File: rtl/kmx_event_queue.sv
module kmx_event_queue #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push,
   input  logic [WIDTH-1:0]         push_data,
   input  logic                     pop,
   output logic [WIDTH-1:0]         head,
   output logic                     empty,
   output logic [$clog2(DEPTH):0]   count,
   output logic                     overflow
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH) + 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("kmx_event_queue: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    rd_ptr, wr_ptr;
   logic             full, do_pop, do_push;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign head    = mem[rd_ptr];

   function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr   <= '0;
         wr_ptr   <= '0;
         count    <= '0;
         overflow <= 1'b0;
      end else begin
         if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
         if (do_push) wr_ptr <= next_ptr(wr_ptr);
         if (do_push && !do_pop)      count <= count + CW'(1);
         else if (do_pop && !do_push) count <= count - CW'(1);
         if (push && !do_push) overflow <= 1'b1;
      end
   end
endmodule

// File: rtl/kmx_matrix_state.sv
module kmx_matrix_state
   import kmx_pkg::*;
#(
   parameter int NUM_SENSE  = 7,
   parameter int NUM_STROBE = 11,
   parameter int NUM_BTN    = 5,
   parameter int BTN_BASE   = 80
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   apply,
   input  logic [7:0]                             code,
   output logic [NUM_SENSE-1:0][NUM_STROBE-1:0]   rows,
   output logic [NUM_BTN-1:0]                     button
);
   kmx_pos_t pos;
   logic     level;

   assign pos   = kmx_lookup(code[6:0], NUM_SENSE, NUM_STROBE, BTN_BASE, NUM_BTN);
   assign level = ~code[7];

   for (genvar r = 0; r < NUM_SENSE; r++) begin : g_row
      for (genvar c = 0; c < NUM_STROBE; c++) begin : g_col
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               rows[r][c] <= 1'b0;
            else if (apply && pos.row == 4'(r) && pos.col == 4'(c))
               rows[r][c] <= level;
         end
      end
   end

   for (genvar b = 0; b < NUM_BTN; b++) begin : g_btn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            button[b] <= 1'b0;
         else if (apply && pos.row == 4'(NUM_SENSE) && pos.col == 4'(b))
            button[b] <= level;
      end
   end
endmodule

// File: rtl/kmx_sense_net.sv
module kmx_sense_net #(
   parameter int NUM_SENSE  = 7,
   parameter int NUM_STROBE = 11
) (
   input  logic [NUM_SENSE-1:0][NUM_STROBE-1:0] rows,
   input  logic [NUM_STROBE-1:0]                strobe,
   output logic [NUM_SENSE-1:0]                 sense
);
   for (genvar r = 0; r < NUM_SENSE; r++) begin : g_sense
      assign sense[r] = |(rows[r] & strobe);
   end
endmodule

// File: rtl/kbd_matrix_emu.sv
module kbd_matrix_emu #(
   parameter int NUM_SENSE   = 7,
   parameter int NUM_STROBE  = 11,
   parameter int NUM_BTN     = 5,
   parameter int BTN_BASE    = 80,
   parameter int QUEUE_DEPTH = 16,
   parameter int TICK_CYCLES = 1562500
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ev_valid,
   input  logic [7:0]            ev_code,
   input  logic [NUM_STROBE-1:0] strobe,
   output logic [NUM_SENSE-1:0]  sense,
   output logic [NUM_BTN-1:0]    button,
   output logic                  overflow
);
   localparam int QCW = $clog2(QUEUE_DEPTH) + 1;

   if (NUM_SENSE < 1 || NUM_SENSE > 14) begin : g_bad_rows
      $error("kbd_matrix_emu: NUM_SENSE must be 1..14");
   end
   if (NUM_STROBE < 1 || NUM_STROBE > 15 || NUM_BTN < 1 || NUM_BTN > 15) begin : g_bad_cols
      $error("kbd_matrix_emu: NUM_STROBE and NUM_BTN must be 1..15");
   end
   if (BTN_BASE < NUM_SENSE * NUM_STROBE || BTN_BASE + NUM_BTN > 128) begin : g_bad_base
      $error("kbd_matrix_emu: button codes must lie above the matrix and below 128");
   end
   if (TICK_CYCLES < 1) begin : g_bad_tick
      $error("kbd_matrix_emu: TICK_CYCLES must be positive");
   end

   logic                                 tick;
   logic [7:0]                           head;
   logic                                 q_empty;
   logic [QCW-1:0]                       q_count;
   logic [NUM_SENSE-1:0][NUM_STROBE-1:0] rows;

   if (TICK_CYCLES == 1) begin : g_tick_every
      assign tick = 1'b1;
   end else begin : g_tick_count
      localparam int TW = $clog2(TICK_CYCLES);
      logic [TW-1:0] tcnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          tcnt <= '0;
         else if (tcnt == TW'(TICK_CYCLES-1)) tcnt <= '0;
         else                                 tcnt <= tcnt + TW'(1);
      end
      assign tick = (tcnt == TW'(TICK_CYCLES-1));
   end

   kmx_event_queue #(.DEPTH(QUEUE_DEPTH), .WIDTH(8)) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (ev_valid),
      .push_data(ev_code),
      .pop      (tick),
      .head     (head),
      .empty    (q_empty),
      .count    (q_count),
      .overflow (overflow)
   );

   kmx_matrix_state #(
      .NUM_SENSE(NUM_SENSE), .NUM_STROBE(NUM_STROBE),
      .NUM_BTN(NUM_BTN), .BTN_BASE(BTN_BASE)
   ) u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .apply (tick && !q_empty),
      .code  (head),
      .rows  (rows),
      .button(button)
   );

   kmx_sense_net #(.NUM_SENSE(NUM_SENSE), .NUM_STROBE(NUM_STROBE)) u_sense (
      .rows  (rows),
      .strobe(strobe),
      .sense (sense)
   );
endmodule

// File: rtl/kmx_matrix_chk.sv
module kmx_matrix_chk #(
   parameter int NUM_SENSE   = 7,
   parameter int NUM_STROBE  = 11,
   parameter int NUM_BTN     = 5,
   parameter int QUEUE_DEPTH = 16,
   parameter int TICK_CYCLES = 2
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [NUM_STROBE-1:0]         strobe,
   input logic [NUM_SENSE-1:0]          sense,
   input logic [NUM_BTN-1:0]            button,
   input logic                          overflow,
   input logic                          tick,
   input logic [$clog2(QUEUE_DEPTH):0]  q_count
);
   localparam int QCW = $clog2(QUEUE_DEPTH) + 1;

   // R2
   strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe == '0 |-> sense == '0);

   // R8
   overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R8
   queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= QCW'(QUEUE_DEPTH));

   // R7
   button_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(button) |-> $past(tick));

   // R7
   queue_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count == $past(q_count)) || (q_count == $past(q_count) + QCW'(1)) ||
      ($past(q_count) == q_count + QCW'(1)));

   if (TICK_CYCLES > 1) begin : g_gap
      // R7
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

bind kbd_matrix_emu kmx_matrix_chk #(
   .NUM_SENSE(NUM_SENSE), .NUM_STROBE(NUM_STROBE), .NUM_BTN(NUM_BTN),
   .QUEUE_DEPTH(QUEUE_DEPTH), .TICK_CYCLES(TICK_CYCLES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .strobe(strobe), .sense(sense),
   .button(button), .overflow(overflow), .tick(tick), .q_count(q_count)
);

// File: tb/sim_kbd_matrix_emu.sv
`timescale 1ns/1ps
module sim_kbd_matrix_emu;
   localparam int NS = 7, NC = 11, NB = 5, QD = 16, TK = 8;
   localparam int DRAIN = (QD + 2) * TK;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ev_valid = 1'b0;
   logic [7:0]    ev_code = '0;
   logic [NC-1:0] strobe = '0;
   logic [NS-1:0] sense;
   logic [NB-1:0] button;
   logic          overflow;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   kbd_matrix_emu #(
      .NUM_SENSE(NS), .NUM_STROBE(NC), .NUM_BTN(NB), .BTN_BASE(80),
      .QUEUE_DEPTH(QD), .TICK_CYCLES(TK)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
      .strobe(strobe), .sense(sense), .button(button), .overflow(overflow)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] c);
      @(negedge clk);
      ev_valid = 1'b1;
      ev_code  = c;
      @(negedge clk);
      ev_valid = 1'b0;
   endtask

   task automatic drain();
      repeat (DRAIN) @(negedge clk);
   endtask

   task automatic t_reset_state();
      chk("R1", "sense at reset", 32'(sense), 0);
      chk("R1", "button at reset", 32'(button), 0);
      chk("R1", "overflow at reset", 32'(overflow), 0);
   endtask

   task automatic t_matrix();
      strobe = '1;
      push(8'd0); push(8'd12); push(8'd76);
      drain();
      chk("R3", "keys r0c0 r1c1 r6c10, all strobes", 32'(sense), 32'b1000011);
      strobe = NC'(1) << 1;
      #1 chk("R2", "strobe col1 only", 32'(sense), 32'b0000010);
      strobe = NC'(1) << 10;
      #1 chk("R2", "strobe col10 only", 32'(sense), 32'b1000000);
      strobe = NC'(1) << 5;
      #1 chk("R2", "strobe unused col5", 32'(sense), 0);
      strobe = '0;
      #1 chk("R2", "no strobes", 32'(sense), 0);
      strobe = '1;
   endtask

   task automatic t_release();
      push(8'h80 | 8'd12);
      push(8'h80 | 8'd22);
      drain();
      chk("R4", "release r1c1 and unpressed r2c0", 32'(sense), 32'b1000001);
   endtask

   task automatic t_buttons();
      push(8'd82);
      drain();
      chk("R5", "button 2 press", 32'(button), 32'b00100);
      chk("R5", "sense unaffected by button", 32'(sense), 32'b1000001);
      push(8'd80); push(8'd84); push(8'h80 | 8'd82);
      drain();
      chk("R5", "buttons 0,4 on, 2 off", 32'(button), 32'b10001);
      push(8'h80 | 8'd80); push(8'h80 | 8'd84);
      drain();
      chk("R5", "all buttons released", 32'(button), 0);
   endtask

   task automatic t_unmapped();
      push(8'd77); push(8'd79); push(8'd85); push(8'd127); push(8'hFF); push(8'hCD);
      drain();
      chk("R6", "sense after unmapped codes", 32'(sense), 32'b1000001);
      chk("R6", "buttons after unmapped codes", 32'(button), 0);
      push(8'h80 | 8'd0); push(8'h80 | 8'd76);
      drain();
      chk("R4", "all keys released", 32'(sense), 0);
   endtask

   task automatic t_pacing();
      int n;
      push(8'd22); push(8'd33);
      n = 0;
      while (!sense[2] && n < 4 * TK) begin @(negedge clk); n++; end
      chk("R7", "first event applied", 32'(sense[2]), 1);
      chk("R7", "second event not yet applied", 32'(sense[3]), 0);
      n = 0;
      while (!sense[3] && n < 4 * TK) begin @(negedge clk); n++; end
      chk("R7", "cycles between events", 32'(n), 32'(TK));
      push(8'h80 | 8'd22); push(8'h80 | 8'd33);
      drain();
   endtask

   task automatic t_wrap();
      push(8'd55); push(8'h80 | 8'd55); push(8'd55); push(8'h80 | 8'd55); push(8'd55);
      drain();
      chk("R9", "order kept across wrap, last is press", 32'(sense), 32'b0100000);
      push(8'h80 | 8'd55);
      drain();
      chk("R9", "final release", 32'(sense), 0);
   endtask

   task automatic t_overflow();
      chk("R8", "no overflow before burst", 32'(overflow), 0);
      @(negedge clk);
      ev_valid = 1'b1;
      ev_code  = 8'd79;
      repeat (24) @(negedge clk);
      ev_valid = 1'b0;
      chk("R8", "overflow after burst", 32'(overflow), 1);
      drain();
      chk("R8", "overflow sticky after drain", 32'(overflow), 1);
   endtask

   task automatic t_reset_midstream();
      push(8'd0);
      drain();
      chk("R1", "key held before reset", 32'(sense), 32'b0000001);
      push(8'd11); push(8'd11); push(8'd81);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1", "sense cleared in reset", 32'(sense), 0);
      chk("R1", "overflow cleared in reset", 32'(overflow), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      drain();
      chk("R1", "queued events discarded (sense)", 32'(sense), 0);
      chk("R1", "queued events discarded (button)", 32'(button), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_matrix();
      t_release();
      t_buttons();
      t_unmapped();
      t_pacing();
      t_wrap();
      t_overflow();
      t_reset_midstream();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule